// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block is the scan counter of a display controller. It runs in the pixel-clock domain and steps a horizontal position across each line and a vertical position down each frame. Both positions are free-running and wrap at limits set by software. Six compare windows are decoded from them. Horizontal sync, horizontal blank and the horizontal pixel-enable window are decoded from the X position. Vertical sync, vertical blank and the vertical pixel-enable window are decoded from the Y position.

Each window has its own start and stop position. A window whose start lies beyond its stop wraps around the end of the line or frame. This lets the pixel-enable window begin before the line start, and lets the vertical pixel-enable window span the frame boundary. Software programs the block through a small synchronous write port with a combinational read-back. Through that port it can also freeze the counters, choose the polarity of each sync output, and read the live position.

Top module: `raster_timing_gen`

## Requirements
- R1: While not frozen, X advances by one per clock. After the value LIMX-1 it returns to 0, so a line lasts LIMX clocks. A limit of 0 or 1 keeps X at 0. LIMX is field [11:0] of the limit register at address 1.
- R2: Y advances by one on each clock in which X wraps, and stays unchanged otherwise. After LIMY-1 it returns to 0. LIMY is field [27:16] of address 1.
- R3: Control bit 0 at address 0 freezes both counters in place. Status address 8 reports that bit in bit 31, X in [11:0] and Y in [27:16].
- R4: A window whose start S is below its stop E is active for positions p with S <= p < E. It is decoded in the same cycle as the counter value. Window registers hold S in [11:0] and E in [27:16]: address 2 horizontal sync, 3 vertical sync, 4 horizontal blank, 5 vertical blank, 6 horizontal pixel enable, 7 vertical pixel enable.
- R5: A window with S greater than E is active when p >= S or p < E. A window with S equal to E is never active.
- R6: Control bit 1 inverts the horizontal sync output and bit 2 inverts the vertical sync output. With the flag set, the output is low while its window is active.
- R7: blank_o is the OR of the two blank windows. pix_en_o is the AND of the two pixel-enable windows.
- R8: A register write takes effect at the clock edge that samples it, with no other delay. A counter found at or above a newly lowered limit returns to 0 on its next advance. For Y, that next advance is the next X wrap.
- R9: Addresses 0 to 7 read back the written fields, with unused bits read as 0. Reads are combinational on the address.
- R10: After reset all registers are zero, both counters are 0, and all four control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 4 | register address |
| cfg_wdata | input | 32 | write data |
| cfg_rdata | output | 32 | read data for cfg_addr |
| hsync_o | output | 1 | horizontal sync after polarity select |
| vsync_o | output | 1 | vertical sync after polarity select |
| blank_o | output | 1 | combined blank |
| pix_en_o | output | 1 | pixel-enable strobe |
| pos_x | output | 12 | current horizontal position |
| pos_y | output | 12 | current vertical position |

## Verification
The counter properties assume software may rewrite a limit at any moment. They therefore compare each step against the limit in force in that same cycle, not against a fixed mode. The window properties assume only that start and stop registers may hold any value, including positions the counter never reaches. The stimulus follows a shadow model that applies each write at the clock edge that samples it. It changes limits while the counters are running, including a directed case that lowers the line length below the current X. Random passes place window edges at or past the limits on purpose.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int DW     = 32;
  localparam int HI_LSB = 16;
  localparam int NWIN   = 6;
  // window slots: even slots decode X, odd slots decode Y
  localparam int W_HSYNC  = 0;
  localparam int W_VSYNC  = 1;
  localparam int W_HBLANK = 2;
  localparam int W_VBLANK = 3;
  localparam int W_HPIX   = 4;
  localparam int W_VPIX   = 5;
  // register addresses
  localparam int A_CTRL   = 0;
  localparam int A_LIMIT  = 1;
  localparam int A_WIN0   = 2;
  localparam int A_STATUS = 8;
endpackage

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] start_pos,
  input  logic [CW-1:0] stop_pos,
  output logic          act
);
  always_comb begin
    if (start_pos < stop_pos)
      act = (pos >= start_pos) && (pos < stop_pos);
    else if (start_pos > stop_pos)
      act = (pos >= start_pos) || (pos < stop_pos);
    else
      act = 1'b0;
  end
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic [CW-1:0] lim_x,
  input  logic [CW-1:0] lim_y,
  output logic [CW-1:0] x_q,
  output logic [CW-1:0] y_q
);
  localparam logic [CW:0] ONE = (CW+1)'(1);

  logic          adv;
  logic          x_last, y_last;
  logic [CW-1:0] x_d, y_d;

  always_comb begin
    adv    = !freeze;
    x_last = ({1'b0, x_q} + ONE) >= {1'b0, lim_x};
    y_last = ({1'b0, y_q} + ONE) >= {1'b0, lim_y};
    x_d    = x_q + CW'(1);
    y_d    = y_q;
    if (x_last) begin
      x_d = '0;
      y_d = y_last ? '0 : y_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [CW-1:0]        cur_x,
  input  logic [CW-1:0]        cur_y,
  output logic                 frz_q,
  output logic                 hinv_q,
  output logic                 vinv_q,
  output logic [CW-1:0]        lim_x,
  output logic [CW-1:0]        lim_y,
  output logic [NWIN-1:0][CW-1:0] win_on,
  output logic [NWIN-1:0][CW-1:0] win_off,
  output logic [DW-1:0]        rdata
);
  logic ctrl_en, lim_en;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[DW-1:HI_LSB+CW], wdata[HI_LSB-1:CW], wdata[CW-1:3]};
  assign ctrl_en = we && (addr == AW'(A_CTRL));
  assign lim_en  = we && (addr == AW'(A_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q  <= 1'b0;
      hinv_q <= 1'b0;
      vinv_q <= 1'b0;
    end else if (ctrl_en) begin
      frz_q  <= wdata[0];
      hinv_q <= wdata[1];
      vinv_q <= wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_x <= '0;
      lim_y <= '0;
    end else if (lim_en) begin
      lim_x <= wdata[CW-1:0];
      lim_y <= wdata[HI_LSB +: CW];
    end
  end

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_pair
    logic pair_en;
    assign pair_en = we && (addr == AW'(A_WIN0 + gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_on[gi]  <= '0;
        win_off[gi] <= '0;
      end else if (pair_en) begin
        win_on[gi]  <= wdata[CW-1:0];
        win_off[gi] <= wdata[HI_LSB +: CW];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTRL)) begin
      rdata[2:0] = {vinv_q, hinv_q, frz_q};
    end else if (addr == AW'(A_LIMIT)) begin
      rdata[CW-1:0]      = lim_x;
      rdata[HI_LSB +: CW] = lim_y;
    end else if (addr == AW'(A_STATUS)) begin
      rdata[CW-1:0]      = cur_x;
      rdata[HI_LSB +: CW] = cur_y;
      rdata[DW-1]        = frz_q;
    end else begin
      for (int i = 0; i < NWIN; i++) begin
        if (addr == AW'(A_WIN0 + i)) begin
          rdata[CW-1:0]      = win_on[i];
          rdata[HI_LSB +: CW] = win_off[i];
        end
      end
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          blank_o,
  output logic          pix_en_o,
  output logic [CW-1:0] pos_x,
  output logic [CW-1:0] pos_y
);
  logic [1:0]                rs_q;
  logic                      rst_sync_n;
  logic                      frz_q, hinv_q, vinv_q;
  logic [CW-1:0]             lim_x, lim_y;
  logic [NWIN-1:0][CW-1:0]   win_on, win_off;
  logic [NWIN-1:0]           win_act;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  rtg_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cur_x(pos_x), .cur_y(pos_y),
    .frz_q(frz_q), .hinv_q(hinv_q), .vinv_q(vinv_q),
    .lim_x(lim_x), .lim_y(lim_y), .win_on(win_on), .win_off(win_off),
    .rdata(cfg_rdata)
  );

  rtg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .freeze(frz_q),
    .lim_x(lim_x), .lim_y(lim_y), .x_q(pos_x), .y_q(pos_y)
  );

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    rtg_window #(.CW(CW)) u_win (
      .pos((gi % 2 == 0) ? pos_x : pos_y),
      .start_pos(win_on[gi]),
      .stop_pos(win_off[gi]),
      .act(win_act[gi])
    );
  end

  assign hsync_o  = win_act[W_HSYNC] ^ hinv_q;
  assign vsync_o  = win_act[W_VSYNC] ^ vinv_q;
  assign blank_o  = win_act[W_HBLANK] | win_act[W_VBLANK];
  assign pix_en_o = win_act[W_HPIX] & win_act[W_VPIX];
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frz,
  input logic [CW-1:0] lim_x,
  input logic [CW-1:0] pos_x,
  input logic [CW-1:0] pos_y,
  input logic [CW-1:0] hs_on,
  input logic [CW-1:0] hs_off,
  input logic          hinv,
  input logic          hsync_o,
  input logic [5:0]    win_act,
  input logic          blank_o,
  input logic          pix_en_o
);
  localparam logic [CW:0] ONE = (CW+1)'(1);
  logic x_mid;
  assign x_mid = ({1'b0, pos_x} + ONE) < {1'b0, lim_x};

  assert_x_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz && x_mid) |=> (pos_x == $past(pos_x) + CW'(1)));

  assert_x_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz && !x_mid) |=> (pos_x == '0));

  assert_y_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz && x_mid) |=> $stable(pos_y));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frz |=> ($stable(pos_x) && $stable(pos_y)));

  assert_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_on == hs_off) |-> (hsync_o == hinv));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act[2] || win_act[3]) |-> blank_o);

  assert_pix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en_o |-> (win_act[4] && win_act[5]));
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .frz(frz_q), .lim_x(lim_x),
  .pos_x(pos_x), .pos_y(pos_y), .hs_on(win_on[0]), .hs_off(win_off[0]),
  .hinv(hinv_q), .hsync_o(hsync_o), .win_act(win_act),
  .blank_o(blank_o), .pix_en_o(pix_en_o)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        hsync_o, vsync_o, blank_o, pix_en_o;
  logic [CW-1:0] pos_x, pos_y;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .blank_o(blank_o), .pix_en_o(pix_en_o),
    .pos_x(pos_x), .pos_y(pos_y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // shadow of the programmed state
  int m_x, m_y, m_frz, m_hinv, m_vinv, m_limx, m_limy;
  int m_on[6], m_off[6];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit win(int p, int s, int e);
    if (s < e) return (p >= s) && (p < e);
    if (s > e) return (p >= s) || (p < e);
    return 1'b0;
  endfunction

  task automatic step();
    if (m_frz == 0) begin
      if (m_x + 1 >= m_limx) begin
        m_x = 0;
        if (m_y + 1 >= m_limy) m_y = 0; else m_y++;
      end else m_x++;
    end
  endtask

  task automatic apply(int a, logic [31:0] d);
    case (a)
      0: begin m_frz = d[0]; m_hinv = d[1]; m_vinv = d[2]; end
      1: begin m_limx = d[11:0]; m_limy = d[27:16]; end
      2, 3, 4, 5, 6, 7: begin m_on[a-2] = d[11:0]; m_off[a-2] = d[27:16]; end
      default: ;
    endcase
  endtask

  task automatic tick();
    @(posedge clk); step(); @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); step(); apply(a, d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    cfg_addr = 4'(a); #1; d = cfg_rdata;
  endtask

  function automatic logic [31:0] pair(int s, int e);
    return {4'h0, 12'(e), 4'h0, 12'(s)};
  endfunction

  // compare every output against the shadow each cycle
  task automatic run(int n, string req);
    int bad[6]; int ga[6]; int ge[6];
    string nm[6] = '{"pos_x", "pos_y", "hsync", "vsync", "blank", "pix_en"};
    for (int k = 0; k < 6; k++) bad[k] = 0;
    for (int i = 0; i < n; i++) begin
      int a[6]; int e[6];
      a[0] = int'(pos_x); a[1] = int'(pos_y); a[2] = hsync_o; a[3] = vsync_o;
      a[4] = blank_o; a[5] = pix_en_o;
      e[0] = m_x; e[1] = m_y;
      e[2] = win(m_x, m_on[0], m_off[0]) ^ m_hinv[0];
      e[3] = win(m_y, m_on[1], m_off[1]) ^ m_vinv[0];
      e[4] = win(m_x, m_on[2], m_off[2]) | win(m_y, m_on[3], m_off[3]);
      e[5] = win(m_x, m_on[4], m_off[4]) & win(m_y, m_on[5], m_off[5]);
      for (int k = 0; k < 6; k++)
        if (a[k] != e[k]) begin
          if (bad[k] == 0) begin ga[k] = a[k]; ge[k] = e[k]; end
          bad[k]++;
        end
      tick();
    end
    for (int k = 0; k < 6; k++)
      chk(bad[k] == 0, req, nm[k], (bad[k] == 0) ? 0 : ga[k], (bad[k] == 0) ? 0 : ge[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int y0, cnt, first;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    m_x = 0; m_y = 0; m_frz = 0; m_hinv = 0; m_vinv = 0; m_limx = 0; m_limy = 0;
    for (int k = 0; k < 6; k++) begin m_on[k] = 0; m_off[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk({hsync_o, vsync_o, blank_o, pix_en_o} == 4'b0, "R10", "outputs", {hsync_o, vsync_o, blank_o, pix_en_o}, 0);
    chk(pos_x == 0 && pos_y == 0, "R10", "position", int'({pos_y, pos_x}), 0);
    rd(1, d); chk(d == 0, "R10", "limit reg", d, 0);
    rd(0, d); chk(d == 0, "R10", "ctrl reg", d, 0);

    // R9 random window readback (limits still 0, counters parked)
    for (int i = 0; i < 8; i++) begin
      int a = 2 + (i % 6);
      logic [31:0] w = $urandom;
      wr(a, w);
      rd(a, d);
      chk(d == (w & 32'h0FFF_0FFF), "R9", "window readback", d, w & 32'h0FFF_0FFF);
    end
    wr(0, 32'h7); rd(0, d); chk(d == 7, "R9", "ctrl readback", d, 7);

    // 640x480 mode, programmed while frozen
    wr(0, 32'h1);
    wr(1, pair(800, 525));
    wr(2, pair(657, 753));
    wr(3, pair(491, 493));
    wr(4, pair(640, 800));
    wr(5, pair(480, 525));
    wr(6, pair(790, 630));
    wr(7, pair(525, 480));
    repeat (20) tick();
    chk(pos_x == 0 && pos_y == 0, "R3", "frozen position", int'(pos_x), 0);
    rd(8, d); chk(d == 32'h8000_0000, "R3", "status word", d, 32'h8000_0000);

    wr(0, 32'h0);
    run(1600, "R1 R2 R4 R5 R7");

    while (pos_x != 0) tick();
    cnt = 0; first = -1;
    for (int i = 0; i < 800; i++) begin
      if (hsync_o) begin cnt++; if (first < 0) first = pos_x; end
      tick();
    end
    chk(cnt == 96, "R4", "hsync width", cnt, 96);
    chk(first == 657, "R4", "hsync start", first, 657);
    cnt = 0;
    for (int i = 0; i < 800; i++) begin if (blank_o) cnt++; tick(); end
    chk(cnt == 160, "R7", "blank per line", cnt, 160);
    cnt = 0;
    for (int i = 0; i < 800; i++) begin if (pix_en_o) cnt++; tick(); end
    chk(cnt == 640, "R5", "wrapped pix window", cnt, 640);

    // R3 freeze while running
    wr(0, 32'h1);
    run(50, "R3");
    wr(0, 32'h0);

    // R8 lower line length below current X
    while (pos_x != 400) tick();
    y0 = pos_y;
    wr(1, pair(8, 525));
    tick();
    chk(pos_x == 0, "R8", "x after shrink", int'(pos_x), 0);
    chk(pos_y == y0 + 1, "R8", "y after shrink", int'(pos_y), y0 + 1);
    run(4300, "R2 R4 R5 R7");

    while (!(pos_x == 0 && pos_y == 0)) tick();
    cnt = 0; first = 0; y0 = 0;
    for (int i = 0; i < 4200; i++) begin
      if (vsync_o) cnt++;
      if (blank_o) first++;
      if (pix_en_o) y0++;
      tick();
    end
    chk(cnt == 16, "R4", "vsync width", cnt, 16);
    chk(first == 360, "R7", "vblank cycles", first, 360);
    chk(y0 == 3840, "R5", "frame-spanning pix window", y0, 3840);

    // R6 polarity
    wr(0, 32'h6);
    run(600, "R6");
    wr(0, 32'h2);
    run(200, "R6");

    // constrained random windows and limits
    for (int it = 0; it < 6; it++) begin
      int lx = 32 + ($urandom % 33);
      int ly = 8 + ($urandom % 9);
      wr(1, pair(lx, ly));
      for (int k = 0; k < 6; k++) begin
        int lim = (k % 2 == 0) ? lx : ly;
        int s = $urandom % (lim + 2);
        int e = $urandom % (lim + 2);
        if (it == 0 && k == 0) e = s;
        if (it == 1) begin s = lim - 2; e = 3; end
        wr(2 + k, pair(s, e));
      end
      wr(0, {29'b0, 2'($urandom), 1'b0});
      run(2 * lx * ly, "R4 R5 R6 R7");
    end
    wr(0, 32'h1);
    rd(8, d);
    chk(d == {1'b1, 3'b0, 12'(m_y), 4'b0, 12'(m_x)}, "R9", "status",
        d, {1'b1, 3'b0, 12'(m_y), 4'b0, 12'(m_x)});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule